// File: doc/BRIEF.md
# Programmable Delay Pulse Generator

This block converts a digital delay word into an interval of clock cycles. A start request, taken while the block is idle, captures the delay word and a mode bit. The delay word has two parts. The coarse part counts groups of eight cycles. The fine part picks one of the eight states of a four-bit twisted-ring (Johnson) counter. The ring is cleared when a start is taken, and it steps once per clock while the block is busy. The coarse down-counter decrements each time the ring wraps.

The end of the interval is found with an all-zero flag. The flag starts at the most significant bit of the coarse counter and is passed down to the least significant bit. The final flag is gated with the decoded ring phase. When both agree, the block emits its stop event. In pulse mode the output is a one-cycle stop pulse. In width mode the output is a level that is high from the cycle after the start until the stop cycle, which gives a pulse-width-modulated signal whose length is the programmed delay.

Top module: `delay_pulse_gen`

## Requirements
- R1: After reset, and at any time while `busy` is low, `busy` and `pulse_out` are both low.
- R2: When `start` is high at a rising edge while `busy` is low, `busy` is high in the following cycle. The delay word and `width_mode` are captured at that edge.
- R3: The delay word is split as `delay_val[14:3]` = coarse count C and `delay_val[2:0]` = fine phase F, giving D = 8*C + F. Cycles are numbered from 0, where cycle 0 is the first cycle with `busy` high. In pulse mode (`width_mode` = 0), `pulse_out` is high for exactly one cycle, cycle D.
- R4: A delay word of zero ends the interval in cycle 0. In pulse mode, the stop pulse appears in that cycle. In width mode, `pulse_out` never rises.
- R5: `busy` is high in the stop cycle D and low in cycle D+1.
- R6: A `start` that arrives while `busy` is high is ignored, including in the stop cycle. While busy, changes on `delay_val` and `width_mode` do not change the interval or the mode.
- R7: In width mode (`width_mode` = 1), `pulse_out` is high in cycles 0 through D-1 and low from the stop cycle D onward. It is therefore high for exactly D cycles.
- R8: The largest delay word, 15'h7FFF, gives an interval of 32767 cycles with no wrap of the coarse counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, taken only when idle |
| delay_val | input | 15 | Delay word: coarse count in bits 14:3, ring phase in bits 2:0 |
| width_mode | input | 1 | 0 selects the stop pulse, 1 selects the width level |
| pulse_out | output | 1 | Stop pulse or width level |
| busy | output | 1 | High from the cycle after an accepted start through the stop cycle |

## Verification
A wrong ring state or a wrong coarse value never causes an early visible error. It moves the stop cycle, so the fault shows at the ports only at the end of the interval. In pulse mode it appears as a pulse in the wrong cycle or a missing pulse. In width mode it appears as a level of the wrong length. A broken busy path or a broken start lock shows within one cycle of the stop cycle or the poked start: busy stays high, or the interval restarts with the poked delay word. The bench therefore measures the position and count of high output cycles over the whole interval, and samples `busy` on both sides of the stop cycle.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

  // Twisted-ring state for phase p of an n-bit ring (2n phases).
  // Phases 0..n-1 fill ones from the bottom; phases n..2n-1 clear them.
  function automatic logic [15:0] jc_state(input int n, input int p);
    int ones_lo;
    int full;
    full = (1 << n) - 1;
    if (p < n) begin
      ones_lo = (1 << p) - 1;
      return 16'(ones_lo);
    end
    ones_lo = (1 << (p - n)) - 1;
    return 16'(full & ~ones_lo);
  endfunction

  // Delay length in cycles for a coarse/fine pair.
  function automatic int interval_len(input int coarse, input int fine, input int ring_w);
    return coarse * (2 * ring_w) + fine;
  endfunction

endpackage

// File: rtl/dpg_phase_ring.sv
module dpg_phase_ring #(
  parameter int JW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  output logic [JW-1:0] state,
  output logic          wrap
);
  import dpg_pkg::*;

  localparam logic [JW-1:0] LAST_ST = JW'(jc_state(JW, 2 * JW - 1));

  logic [JW-1:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (clear) begin
      state_q <= '0;
    end else if (step) begin
      state_q <= {state_q[JW-2:0], ~state_q[JW-1]};
    end
  end

  assign state = state_q;
  assign wrap  = (state_q == LAST_ST);

endmodule

// File: rtl/dpg_coarse_down.sv
module dpg_coarse_down #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] count,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic          zflag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // Zero flag enters at the top bit and is handed down bit by bit.
  always_comb begin
    zflag = 1'b1;
    for (int i = CW - 1; i >= 0; i--) begin
      zflag = zflag & ~cnt_q[i];
    end
  end

  assign count = cnt_q;
  assign zero  = zflag;

endmodule

// File: rtl/dpg_seq.sv
module dpg_seq #(
  parameter int JW = 4,
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] fine_in,
  input  logic          mode_in,
  input  logic          coarse_zero,
  input  logic [JW-1:0] ring_state,
  output logic          busy_q,
  output logic          mode_q,
  output logic          start_acc,
  output logic          stop_evt,
  output logic          advance
);
  import dpg_pkg::*;

  logic [FW-1:0] fine_q;
  logic [JW-1:0] target_st;
  logic          phase_match;

  assign start_acc   = start & ~busy_q;
  assign target_st   = JW'(jc_state(JW, int'(fine_q)));
  assign phase_match = (ring_state == target_st);
  assign stop_evt    = busy_q & coarse_zero & phase_match;
  assign advance     = busy_q & ~stop_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mode_q <= 1'b0;
      fine_q <= '0;
    end else if (start_acc) begin
      busy_q <= 1'b1;
      mode_q <= mode_in;
      fine_q <= fine_in;
    end else if (stop_evt) begin
      busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/delay_pulse_gen.sv
module delay_pulse_gen #(
  parameter int CW = 12,
  parameter int JW = 4,
  parameter int FW = $clog2(2 * JW),
  parameter int DW = CW + FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] delay_val,
  input  logic          width_mode,
  output logic          pulse_out,
  output logic          busy
);

  logic [JW-1:0] ring_state;
  logic          ring_wrap;
  logic [CW-1:0] coarse_cnt;
  logic          coarse_zero;
  logic          busy_q;
  logic          mode_q;
  logic          start_acc;
  logic          stop_evt;
  logic          advance;

  dpg_seq #(.JW(JW), .FW(FW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .fine_in    (delay_val[FW-1:0]),
    .mode_in    (width_mode),
    .coarse_zero(coarse_zero),
    .ring_state (ring_state),
    .busy_q     (busy_q),
    .mode_q     (mode_q),
    .start_acc  (start_acc),
    .stop_evt   (stop_evt),
    .advance    (advance)
  );

  dpg_phase_ring #(.JW(JW)) u_ring (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(start_acc),
    .step (advance),
    .state(ring_state),
    .wrap (ring_wrap)
  );

  dpg_coarse_down #(.CW(CW)) u_coarse (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_acc),
    .load_val(delay_val[DW-1:FW]),
    .dec     (advance & ring_wrap),
    .count   (coarse_cnt),
    .zero    (coarse_zero)
  );

  assign busy      = busy_q;
  assign pulse_out = mode_q ? (busy_q & ~stop_evt) : stop_evt;

endmodule

// File: rtl/dpg_checker.sv
module dpg_checker #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          pulse_out,
  input logic          stop_evt,
  input logic          mode_q,
  input logic          coarse_zero,
  input logic [CW-1:0] coarse_cnt
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pulse_out);

  // R2
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R3
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_out && !mode_q) |=> !pulse_out);

  // R3
  zero_ripple_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_zero == (coarse_cnt == '0));

  // R5
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !busy);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stop_evt) |=> (busy && $stable(mode_q)));

  // R7
  width_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q && !stop_evt) |-> pulse_out);

  // R7
  width_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && stop_evt) |-> !pulse_out);

endmodule

bind delay_pulse_gen dpg_checker #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .pulse_out  (pulse_out),
  .stop_evt   (stop_evt),
  .mode_q     (mode_q),
  .coarse_zero(coarse_zero),
  .coarse_cnt (coarse_cnt)
);

// File: tb/sim_delay_pulse_gen.sv
`timescale 1ns/1ps
module sim_delay_pulse_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [14:0] delay_val = '0;
  logic        width_mode = 1'b0;
  logic        pulse_out;
  logic        busy;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  delay_pulse_gen u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .delay_val (delay_val),
    .width_mode(width_mode),
    .pulse_out (pulse_out),
    .busy      (busy)
  );

  // {poke, mode, coarse[11:0], fine[2:0]}
  localparam logic [16:0] VECS [10] = '{
    {1'b0, 1'b0, 12'd0,  3'd0},
    {1'b0, 1'b0, 12'd0,  3'd5},
    {1'b0, 1'b0, 12'd1,  3'd0},
    {1'b0, 1'b0, 12'd2,  3'd7},
    {1'b0, 1'b1, 12'd0,  3'd3},
    {1'b0, 1'b1, 12'd3,  3'd1},
    {1'b0, 1'b1, 12'd0,  3'd0},
    {1'b1, 1'b0, 12'd10, 3'd2},
    {1'b1, 1'b1, 12'd4,  3'd6},
    {1'b1, 1'b0, 12'd0,  3'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_one(input bit mode, input int coarse, input int fine, input bit poke);
    int d;
    int first_hi;
    int last_hi;
    int n_hi;
    int busy_at_d;
    int busy_after;
    d = coarse * 8 + fine;
    first_hi = -1;
    last_hi = -1;
    n_hi = 0;
    busy_at_d = 0;
    busy_after = 1;
    @(negedge clk);
    start = 1'b1;
    delay_val = {12'(coarse), 3'(fine)};
    width_mode = mode;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    for (int k = 0; k <= d + 1; k++) begin
      if (pulse_out) begin
        if (first_hi < 0) first_hi = k;
        last_hi = k;
        n_hi++;
      end
      if (k == d) busy_at_d = int'(busy);
      if (k == d + 1) busy_after = int'(busy);
      if (poke && (k == 0 || k == d)) begin
        start = 1'b1;
        delay_val = ~delay_val;
        width_mode = ~mode;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    width_mode = mode;
    if (!mode) begin
      if (d == 0) check(first_hi == 0, "R4 zero delay pulse cycle", first_hi, 0);
      else        check(first_hi == d, "R3 stop pulse cycle", first_hi, d);
      check(n_hi == 1, "R3 stop pulse length", n_hi, 1);
    end else begin
      if (d == 0) check(n_hi == 0, "R4 zero delay width", n_hi, 0);
      else begin
        check(n_hi == d, "R7 width high cycles", n_hi, d);
        check(first_hi == 0 && last_hi == d - 1, "R7 width window end", last_hi, d - 1);
      end
    end
    check(busy_at_d == 1 && busy_after == 0, "R5 busy fall", busy_after, 0);
    if (poke) begin
      if (!mode) check(first_hi == d && n_hi == 1, "R6 busy start ignored", first_hi, d);
      else       check(n_hi == d, "R6 busy start ignored", n_hi, d);
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    check(pulse_out == 1'b0, "R1 reset output", int'(pulse_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 10; v++) begin
      run_one(VECS[v][15], int'(VECS[v][14:3]), int'(VECS[v][2:0]), VECS[v][16]);
    end

    // R8: full-scale delay word
    run_one(1'b0, 4095, 7, 1'b0);

    // R1: reset in the middle of an interval returns to idle
    @(negedge clk);
    start = 1'b1;
    delay_val = {12'd12, 3'd4};
    width_mode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(busy == 1'b0, "R1 mid-run reset busy", int'(busy), 0);
    check(pulse_out == 1'b0, "R1 mid-run reset output", int'(pulse_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && pulse_out == 1'b0, "R1 idle after reset", int'(busy), 0);

    // R2: fresh interval after reset
    run_one(1'b1, 1, 2, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule